// File: doc/BRIEF.md
# Translation Region Selector

This block decides which of two translation regions an incoming 64-bit input address belongs to. One region sits at the bottom of the address space and is reached by addresses whose upper bits are all zero. The other sits at the top and is reached by addresses whose upper bits are all one. Each region has a 6-bit size field, `tsz`, which gives the number of upper address bits that must match. Each region also has a disable flag. Two top-byte-ignore enables complete the configuration: when the applicable one is set, the top 8 address bits play no part in the check.

The selector is purely combinational. It drives a region index, a valid flag that says the index is meaningful, and a translation-fault flag. The decision resolves to one of five named outcomes:
- `PICK_LO_HIT`: the lower region's check passed.
- `PICK_HI_HIT`: the upper region's check passed.
- `PICK_LO_REST`: the lower region has a size of zero, so it claims every address not taken by the upper region.
- `PICK_HI_REST`: the upper region has a size of zero and claims the remainder.
- `PICK_GAP`: the address falls between two sized regions.

The result feeds a table walker, which reads the region index and stops the access when the fault flag is set.

Top module: `region_selector`

## Requirements
- R1: Address bit 55 selects which top-byte-ignore enable applies. When bit 55 is 1 the upper-region enable applies; when it is 0 the lower-region enable applies. The applicable enable is used for both region checks.
- R2: When the applicable top-byte-ignore enable is set, address bits 63:56 are excluded from both region checks.
- R3: If the lower region's effective tsz is nonzero and the checked upper bits are all zero, the lower region is selected. The checked bits are 63 down to 64−tsz, minus any ignored top byte. The outputs are index 0 and valid 1.
- R4: If the upper region's effective tsz is nonzero and its checked upper bits are all one, the upper region is selected. The outputs are index 1 and valid 1.
- R5: If neither check passes and the lower tsz is zero, the lower region (index 0, valid 1) is selected. This includes the case where both sizes are zero.
- R6: If neither check passes, the lower tsz is nonzero and the upper tsz is zero, the upper region (index 1, valid 1) is selected.
- R7: If neither check passes and both sizes are nonzero, the outputs are valid 0, index 0 and translation fault 1.
- R8: When the selected region's disable flag is set, translation fault is 1, valid stays 1 and the index still names that region. Otherwise an address that selects a region has a fault of 0.
- R9: A tsz of 0 is kept as 0. Values 1 to 15 are treated as 16, and values above 39 are treated as 39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 64 | Input address to classify |
| lo_tsz | input | 6 | Lower region size field |
| lo_off | input | 1 | Lower region disabled |
| lo_tbi | input | 1 | Top-byte-ignore enable used when bit 55 is 0 |
| hi_tsz | input | 6 | Upper region size field |
| hi_off | input | 1 | Upper region disabled |
| hi_tbi | input | 1 | Top-byte-ignore enable used when bit 55 is 1 |
| region_idx | output | 1 | Selected region: 0 lower, 1 upper |
| region_valid | output | 1 | A region was selected |
| xlat_fault | output | 1 | Translation fault (gap or disabled region) |

## Verification
The embedded assertions are evaluated on every input change. They check four things:
- The two span checkers never both report a match.
- Every gap outcome faults with index 0.
- A fault-free selection never names a disabled region.
- A zero lower size always yields the lower region when the upper check fails, and the clamped sizes stay inside their legal range.

Only the bench's scenarios can show which bits each check actually covers. That covers the effect of bit 55 on the top-byte-ignore choice, the exact clamping points, and the exact index returned for each address pattern. These require known addresses with hand-derived answers.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    typedef enum logic [2:0] {
        PICK_LO_HIT  = 3'd0,
        PICK_HI_HIT  = 3'd1,
        PICK_LO_REST = 3'd2,
        PICK_HI_REST = 3'd3,
        PICK_GAP     = 3'd4
    } pick_e;

    localparam logic REGION_LO = 1'b0;
    localparam logic REGION_HI = 1'b1;

endpackage

// File: rtl/tsz_clamp.sv
module tsz_clamp #(
    parameter int TSZ_W   = 6,
    parameter int TSZ_MIN = 16,
    parameter int TSZ_MAX = 39
) (
    input  logic [TSZ_W-1:0] raw,
    output logic [TSZ_W-1:0] eff
);
    localparam logic [TSZ_W-1:0] MIN_V = TSZ_W'(TSZ_MIN);
    localparam logic [TSZ_W-1:0] MAX_V = TSZ_W'(TSZ_MAX);

    always_comb begin
        if (raw == '0)
            eff = '0;
        else if (raw < MIN_V)
            eff = MIN_V;
        else if (raw > MAX_V)
            eff = MAX_V;
        else
            eff = raw;
    end

    // R9: a size is either "no region" or inside the legal band
    always_comb begin
        assert_clamp_band_R9: assert (eff == '0 || (eff >= MIN_V && eff <= MAX_V));
    end
endmodule

// File: rtl/span_check.sv
module span_check #(
    parameter int ADDR_W = 64,
    parameter int TOP_W  = 8,
    parameter int TSZ_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TSZ_W-1:0]  tsz,
    input  logic              tbi_on,
    output logic              all_zero,
    output logic              all_one
);
    logic [ADDR_W-1:0] zero_ok;
    logic [ADDR_W-1:0] one_ok;
    int                lo_edge;
    int                hi_edge;

    // Checked window is [hi_edge-1 : lo_edge]; top byte drops out when ignored.
    assign lo_edge = ADDR_W - int'(tsz);
    assign hi_edge = tbi_on ? (ADDR_W - TOP_W) : ADDR_W;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        logic in_win;
        assign in_win     = (i >= lo_edge) && (i < hi_edge);
        assign zero_ok[i] = !in_win || !addr[i];
        assign one_ok[i]  = !in_win ||  addr[i];
    end

    assign all_zero = &zero_ok;
    assign all_one  = &one_ok;
endmodule

// File: rtl/region_selector.sv
module region_selector
    import rsel_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TOP_W   = 8,
    parameter int TSZ_W   = 6,
    parameter int TSZ_MIN = 16,
    parameter int TSZ_MAX = 39
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [TSZ_W-1:0]  lo_tsz,
    input  logic              lo_off,
    input  logic              lo_tbi,
    input  logic [TSZ_W-1:0]  hi_tsz,
    input  logic              hi_off,
    input  logic              hi_tbi,
    output logic              region_idx,
    output logic              region_valid,
    output logic              xlat_fault
);
    localparam int TBI_BIT = ADDR_W - TOP_W - 1;

    logic [TSZ_W-1:0] raw_tsz [2];
    logic [TSZ_W-1:0] eff_tsz [2];
    logic [1:0]       span_zero;
    logic [1:0]       span_one;
    logic             tbi_on;
    logic             lo_match;
    logic             hi_match;
    pick_e            pick;

    assign raw_tsz[0] = lo_tsz;
    assign raw_tsz[1] = hi_tsz;

    // R1: one ignore enable, chosen by the sign-like bit, serves both checks
    assign tbi_on = addr[TBI_BIT] ? hi_tbi : lo_tbi;

    for (genvar r = 0; r < 2; r++) begin : g_region
        tsz_clamp #(
            .TSZ_W   (TSZ_W),
            .TSZ_MIN (TSZ_MIN),
            .TSZ_MAX (TSZ_MAX)
        ) u_clamp (
            .raw (raw_tsz[r]),
            .eff (eff_tsz[r])
        );

        span_check #(
            .ADDR_W (ADDR_W),
            .TOP_W  (TOP_W),
            .TSZ_W  (TSZ_W)
        ) u_span (
            .addr     (addr),
            .tsz      (eff_tsz[r]),
            .tbi_on   (tbi_on),
            .all_zero (span_zero[r]),
            .all_one  (span_one[r])
        );
    end

    assign lo_match = (eff_tsz[0] != '0) && span_zero[0];
    assign hi_match = (eff_tsz[1] != '0) && span_one[1];

    // Outcome decision, in priority order
    always_comb begin
        if (lo_match)
            pick = PICK_LO_HIT;
        else if (hi_match)
            pick = PICK_HI_HIT;
        else if (eff_tsz[0] == '0)
            pick = PICK_LO_REST;
        else if (eff_tsz[1] == '0)
            pick = PICK_HI_REST;
        else
            pick = PICK_GAP;
    end

    // Outputs per outcome
    always_comb begin
        unique case (pick)
            PICK_LO_HIT, PICK_LO_REST: begin
                region_idx   = REGION_LO;
                region_valid = 1'b1;
                xlat_fault   = lo_off;
            end
            PICK_HI_HIT, PICK_HI_REST: begin
                region_idx   = REGION_HI;
                region_valid = 1'b1;
                xlat_fault   = hi_off;
            end
            default: begin
                region_idx   = REGION_LO;
                region_valid = 1'b0;
                xlat_fault   = 1'b1;
            end
        endcase
    end

    // Checks across the separate span checkers and the outputs
    always_comb begin
        assert_single_match_R3: assert (!(lo_match && hi_match));
        if (!region_valid)
            assert_gap_faults_R7: assert (xlat_fault && region_idx == REGION_LO);
        if (region_valid && !xlat_fault)
            assert_enabled_pick_R8: assert ((region_idx == REGION_LO) ? !lo_off : !hi_off);
        if (lo_tsz == '0 && !hi_match)
            assert_lo_default_R5: assert (region_valid && region_idx == REGION_LO);
    end
endmodule

// File: tb/region_selector_test.sv
module region_selector_test;

    typedef struct packed {
        logic [63:0] addr;
        logic [5:0]  lo_tsz;
        logic [5:0]  hi_tsz;
        logic        lo_off;
        logic        hi_off;
        logic        lo_tbi;
        logic        hi_tbi;
        logic        e_idx;
        logic        e_valid;
        logic        e_fault;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // R3 plain lower hit
        '{64'h0000_0000_0000_1000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},
        // R4 plain upper hit
        '{64'hFFFF_FF80_0000_0000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},
        // R7 gap
        '{64'h0000_8000_0000_0000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7},
        // R2 tagged lower address with lower ignore enable
        '{64'hAB00_0000_0000_1000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
        // R1 bit 55 is 0, so the upper enable does not apply
        '{64'hAB00_0000_0000_1000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1},
        // R1 bit 55 is 1, so the upper enable applies
        '{64'h12FF_FF80_0000_0000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1},
        // R1 bit 55 is 1, so the lower enable does not apply
        '{64'h12FF_FF80_0000_0000, 6'd25, 6'd25, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
        // R5 lower size zero takes the rest
        '{64'h0000_8000_0000_0000, 6'd0,  6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},
        // R5 both sizes zero
        '{64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},
        // R6 upper size zero takes the rest
        '{64'hFFFF_0000_0000_0000, 6'd25, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
        // R6 a lower hit still wins over the upper default
        '{64'h0000_0000_0000_1000, 6'd25, 6'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd6},
        // R8 lower region disabled
        '{64'h0000_0000_0000_1000, 6'd25, 6'd25, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8},
        // R8 upper region disabled
        '{64'hFFFF_FF80_0000_0000, 6'd25, 6'd25, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd8},
        // R9 size 4 is treated as 16, so bit 48 falls inside the window
        '{64'h0001_0000_0000_0000, 6'd4,  6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},
        // R9 size 63 is treated as 39, so bit 20 falls outside the window
        '{64'h0000_0000_0010_0000, 6'd63, 6'd25, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9}
    };

    logic        clk = 1'b0;
    logic [63:0] addr;
    logic [5:0]  lo_tsz, hi_tsz;
    logic        lo_off, hi_off, lo_tbi, hi_tbi;
    logic        region_idx, region_valid, xlat_fault;
    int          n_checks = 0;
    int          n_fail   = 0;
    logic        finished = 1'b0;

    always #2 clk = ~clk;

    region_selector uut (
        .addr         (addr),
        .lo_tsz       (lo_tsz),
        .lo_off       (lo_off),
        .lo_tbi       (lo_tbi),
        .hi_tsz       (hi_tsz),
        .hi_off       (hi_off),
        .hi_tbi       (hi_tbi),
        .region_idx   (region_idx),
        .region_valid (region_valid),
        .xlat_fault   (xlat_fault)
    );

    task automatic apply(input vec_t v);
        @(posedge clk);
        addr   = v.addr;
        lo_tsz = v.lo_tsz;
        hi_tsz = v.hi_tsz;
        lo_off = v.lo_off;
        hi_off = v.hi_off;
        lo_tbi = v.lo_tbi;
        hi_tbi = v.hi_tbi;
        @(negedge clk);
        n_checks++;
        if ({region_idx, region_valid, xlat_fault} !== {v.e_idx, v.e_valid, v.e_fault}) begin
            n_fail++;
            $display("FAIL R%0d addr=%h got idx/valid/fault=%b%b%b expected %b%b%b",
                     v.req, v.addr, region_idx, region_valid, xlat_fault,
                     v.e_idx, v.e_valid, v.e_fault);
        end
    endtask

    initial begin
        // Start-up state: all inputs zero means both sizes are zero, so R5 applies
        apply('{64'h0, 6'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5});
        for (int k = 0; k < NV; k++)
            apply(VECS[k]);
        // R2 minimum size with the ignored top byte: window shrinks to bits 55:48
        apply('{64'h00FF_0000_0000_0000, 6'd16, 6'd16, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2});
        // R2 lower side: top byte set, bit 55 clear, lower enable on
        apply('{64'hFF00_0000_0000_0000, 6'd16, 6'd16, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2});
        // R9 size 10 is treated as 16; bits 63:48 all ones give an upper hit
        apply('{64'hFFFF_0000_0000_0000, 6'd25, 6'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9});
        // R7 gap with both regions disabled still reports no region
        apply('{64'h0000_8000_0000_0000, 6'd25, 6'd25, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd7});
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule